// File: doc/BRIEF.md
# Serial Burst Master Shifter

This block is a synchronous-serial master. It produces a serial clock from the system clock and drives a single active-low select line. It shifts words out on a data output and samples a data input. A small register port holds the configuration, a clock divider, up to four transmit words and up to four receive words. Software fills the transmit words and sets the divider. It then writes the control word with the start bit set. One start sends a burst of one to four words back to back.

For each burst, the control word selects:
- the word length, from 1 to 32 bits;
- the bit order;
- whether the output changes on the rising or the falling serial-clock edge;
- whether the input is sampled on the rising or the falling serial-clock edge.

The busy flag reads back in control bit 0 for as long as the burst runs. While the block is busy, every register write is discarded. A one-cycle done strobe marks the end of the burst.

Register map (word addresses): 0 control, 1 divider, 4..7 transmit words 0..3 (read/write), 8..11 receive words 0..3 (read only). Other addresses read zero.

Top module: `spi_burst_master`

## Requirements
- R1: After reset the serial clock and data output are low, the select is high, done is low, and the control, divider, transmit and receive registers all read zero.
- R2: Control bits [5:1] give the word length. Codes 1..31 mean that many bits and code 0 means 32 bits. A burst keeps the select low for exactly 2*bits*words*(divider+1) system cycles.
- R3: Control bits [7:6] give the burst size. Codes 0,1,2,3 mean 1,2,3,4 words. Words go in ascending index order from word 0, with the serial clock running without a gap between words.
- R4: Control bit 8 sets the bit order. When it is 0, transmit bit (len-1) goes out first and the first received bit lands in receive bit (len-1). When it is 1, bit 0 goes out first and the first received bit lands in receive bit 0.
- R5: Control bit 9 selects the launch edge. When it is 1, the output changes on serial-clock falling edges. When it is 0, the output changes on rising edges, and the first bit is already driven when the burst starts.
- R6: Control bit 10 selects the capture edge. When it is 0, the input is sampled on serial-clock rising edges. When it is 1, it is sampled on falling edges.
- R7: Each serial-clock phase lasts (divider+1) system cycles, with the divider taken from register 1 bits [15:0]. The clock is low outside a burst, and the select stays low for the whole burst.
- R8: Writing control bit 0 as 1 starts a burst in the next cycle. Writing it as 0 only updates the fields. Control bit 0 reads 1 throughout the burst and 0 after it.
- R9: Any register write made while busy is discarded. This covers transmit words, the divider and the control word, including a new start.
- R10: At the start of a burst all receive words are cleared. Bits at or above the word length therefore read zero.
- R11: Done is high for exactly the one cycle in which busy has just cleared.
- R12: The control word reads back its configuration fields in the same bit positions, with busy in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | 1 | Select, low during a burst |
| done_o | output | 1 | One-cycle end-of-burst strobe |

## Verification
The serial input is looped back from the output, inverted on some runs. Every combination of launch edge, capture edge and bit order is run once, with word lengths 1, 3, 5, 8, 13, 16, 31 and 32, burst sizes 1 to 4 and several divider values. The loopback separates the capture edges: with both edges rising, each received bit is the previous transmitted bit, while every other pairing returns the same bit. This exposes any edge or order swap as a shifted or mirrored receive word. Runs with short words show whether stale upper receive bits are cleared. A long burst receives writes to a transmit word, the divider and the control word in mid-flight, and they are read back afterwards to confirm the lock.

// File: rtl/spi_burst_pkg.sv
`timescale 1ns/1ps
package spi_burst_pkg;
  localparam int unsigned LEN_CODE_W = 5;
  localparam int unsigned CNT_W      = 2;
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_DIV   = 1;
  localparam int unsigned ADDR_TX    = 4;
  localparam int unsigned ADDR_RX    = 8;

  // control word bits [10:1]; bit 0 is go/busy
  typedef struct packed {
    logic                  capture_fall;
    logic                  launch_fall;
    logic                  lsb_first;
    logic [CNT_W-1:0]      word_cnt;
    logic [LEN_CODE_W-1:0] len_code;
  } spi_cfg_t;

  localparam int unsigned CFG_W = $bits(spi_cfg_t);
endpackage

// File: rtl/spi_clk_div.sv
`timescale 1ns/1ps
module spi_clk_div #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             tick;

  assign tick = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = tick & ~sclk_q;
  assign fall_o = tick & sclk_q;
endmodule

// File: rtl/spi_bit_seq.sv
`timescale 1ns/1ps
module spi_bit_seq #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned WIDX_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fall_i,
  input  logic [IDX_W-1:0]  len_m1_i,
  input  logic [WIDX_W-1:0] last_word_i,
  output logic [IDX_W-1:0]  pos_o,
  output logic [WIDX_W-1:0] word_o,
  output logic [IDX_W-1:0]  nxt_pos_o,
  output logic [WIDX_W-1:0] nxt_word_o,
  output logic              first_o,
  output logic              end_o
);
  logic [IDX_W-1:0]  pos_q;
  logic [WIDX_W-1:0] word_q;
  logic              word_end;

  assign word_end   = (pos_q == len_m1_i);
  assign nxt_pos_o  = word_end ? '0 : pos_q + 1'b1;
  assign nxt_word_o = word_end ? word_q + 1'b1 : word_q;
  assign end_o      = fall_i && word_end && (word_q == last_word_i);
  assign first_o    = (pos_q == '0) && (word_q == '0);
  assign pos_o      = pos_q;
  assign word_o     = word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      word_q <= '0;
    end else if (start_i) begin
      pos_q  <= '0;
      word_q <= '0;
    end else if (fall_i) begin
      pos_q  <= nxt_pos_o;
      word_q <= nxt_word_o;
    end
  end
endmodule

// File: rtl/spi_data_bank.sv
`timescale 1ns/1ps
module spi_data_bank #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned WIDX_W    = 2,
  parameter int unsigned IDX_W     = 5
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                tx_we_i,
  input  logic [WIDX_W-1:0]                   tx_idx_i,
  input  logic [DATA_W-1:0]                   tx_data_i,
  input  logic                                rx_clr_i,
  input  logic                                cap_en_i,
  input  logic [WIDX_W-1:0]                   cap_word_i,
  input  logic [IDX_W-1:0]                    cap_pos_i,
  input  logic                                cap_bit_i,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]    tx_o,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]    rx_o
);
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tx_o[i] <= '0;
      else if (tx_we_i && tx_idx_i == WIDX_W'(i)) tx_o[i] <= tx_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rx_o[i] <= '0;
      else if (rx_clr_i) rx_o[i] <= '0;
      else if (cap_en_i && cap_word_i == WIDX_W'(i)) rx_o[i][cap_pos_i] <= cap_bit_i;
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
`timescale 1ns/1ps
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 4,
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              ss_no,
  output logic              done_o
);
  localparam int unsigned IDX_W  = LEN_CODE_W;
  localparam int unsigned WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  spi_cfg_t         cfg_q, cfg_new;
  logic [DIV_W-1:0] div_q;
  logic             busy_q, done_q, mosi_q;
  logic             wr_ok, ctrl_we, go, tx_we;
  logic [ADDR_W-1:0] tx_off, rx_off;
  logic [IDX_W-1:0] len_m1, start_pos;
  logic             rise, fall, seq_end, first, cap_en;
  logic [IDX_W-1:0] cur_p, nxt_p;
  logic [WIDX_W-1:0] cur_w, nxt_w;
  logic [NUM_WORDS-1:0][DATA_W-1:0] tx_arr, rx_arr;

  function automatic logic [IDX_W-1:0] pos_of(input logic [IDX_W-1:0] p,
                                              input logic lsb,
                                              input logic [IDX_W-1:0] lm1);
    return lsb ? p : lm1 - p;
  endfunction

  assign wr_ok   = reg_we_i & ~busy_q;
  assign ctrl_we = wr_ok && (reg_addr_i == ADDR_W'(ADDR_CTRL));
  assign go      = ctrl_we & reg_wdata_i[0];
  assign tx_off  = reg_addr_i - ADDR_W'(ADDR_TX);
  assign rx_off  = reg_addr_i - ADDR_W'(ADDR_RX);
  assign tx_we   = wr_ok && (tx_off < ADDR_W'(NUM_WORDS));
  assign cfg_new = spi_cfg_t'(reg_wdata_i[CFG_W:1]);
  // code 0 wraps to all ones: 32-bit word
  assign len_m1    = cfg_q.len_code - IDX_W'(1);
  assign start_pos = cfg_new.lsb_first ? '0 : cfg_new.len_code - IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      div_q <= '0;
    end else begin
      if (ctrl_we) cfg_q <= cfg_new;
      if (wr_ok && reg_addr_i == ADDR_W'(ADDR_DIV)) div_q <= reg_wdata_i[DIV_W-1:0];
    end
  end

  spi_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i(busy_q), .div_i(div_q),
    .sclk_o, .rise_o(rise), .fall_o(fall)
  );

  spi_bit_seq #(.IDX_W(IDX_W), .WIDX_W(WIDX_W)) u_seq (
    .clk_i, .rst_ni, .start_i(go), .fall_i(fall),
    .len_m1_i(len_m1), .last_word_i(WIDX_W'(cfg_q.word_cnt)),
    .pos_o(cur_p), .word_o(cur_w), .nxt_pos_o(nxt_p), .nxt_word_o(nxt_w),
    .first_o(first), .end_o(seq_end)
  );

  assign cap_en = cfg_q.capture_fall ? fall : rise;

  spi_data_bank #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .WIDX_W(WIDX_W), .IDX_W(IDX_W)) u_bank (
    .clk_i, .rst_ni,
    .tx_we_i(tx_we), .tx_idx_i(tx_off[WIDX_W-1:0]), .tx_data_i(reg_wdata_i),
    .rx_clr_i(go), .cap_en_i(cap_en), .cap_word_i(cur_w),
    .cap_pos_i(pos_of(cur_p, cfg_q.lsb_first, len_m1)), .cap_bit_i(miso_i),
    .tx_o(tx_arr), .rx_o(rx_arr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      done_q <= seq_end;
      if (go) begin
        busy_q <= 1'b1;
        mosi_q <= tx_arr[0][start_pos];
      end else if (seq_end) begin
        busy_q <= 1'b0;
        mosi_q <= 1'b0;
      end else if (fall && cfg_q.launch_fall) begin
        mosi_q <= tx_arr[nxt_w][pos_of(nxt_p, cfg_q.lsb_first, len_m1)];
      end else if (rise && !cfg_q.launch_fall && !first) begin
        // first bit was set up at start; later bits move on rising edges
        mosi_q <= tx_arr[cur_w][pos_of(cur_p, cfg_q.lsb_first, len_m1)];
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(ADDR_CTRL))
      reg_rdata_o = DATA_W'({cfg_q, busy_q});
    else if (reg_addr_i == ADDR_W'(ADDR_DIV))
      reg_rdata_o = DATA_W'(div_q);
    else if (tx_off < ADDR_W'(NUM_WORDS))
      reg_rdata_o = tx_arr[tx_off[WIDX_W-1:0]];
    else if (rx_off < ADDR_W'(NUM_WORDS))
      reg_rdata_o = rx_arr[rx_off[WIDX_W-1:0]];
  end

  assign mosi_o = mosi_q;
  assign ss_no  = ~busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/spi_burst_master_chk.sv
`timescale 1ns/1ps
module spi_burst_master_chk #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned LEN_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sclk_o,
  input logic             mosi_o,
  input logic             ss_no,
  input logic             done_o,
  input logic             busy_i,
  input logic [DIV_W-1:0] div_i,
  input logic [LEN_W-1:0] len_i
);
  // R7
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_no |-> !sclk_o);
  // R5
  mosi_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_no |-> !mosi_o);
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ss_no && $past(busy_i)));
  // R9
  div_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(div_i));
  // R9
  len_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(len_i));
endmodule

bind spi_burst_master spi_burst_master_chk #(.DIV_W(DIV_W), .LEN_W(spi_burst_pkg::LEN_CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_o(sclk_o), .mosi_o(mosi_o),
  .ss_no(ss_no), .done_o(done_o), .busy_i(busy_q), .div_i(div_q),
  .len_i(cfg_q.len_code)
);

// File: tb/spi_burst_master_bench.sv
`timescale 1ns/1ps
module spi_burst_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata;
  logic        sclk, mosi, miso, ss_n, done;
  logic        miso_inv = 1'b0;

  int vec = 0;
  int bad = 0;
  int cyc = 0;

  logic [31:0] txw [4];
  logic [31:0] exp_rx [4];
  logic [31:0] seed = 32'h1234_5678;
  int          lenb;
  logic        lsb_m;

  always #2.5 clk = ~clk;
  assign miso = mosi ^ miso_inv;

  spi_burst_master u_spi_burst_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .ss_no(ss_n), .done_o(done)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return {seed[15:0], seed[31:16]};
  endfunction

  function automatic logic txbit(int g);
    int w = g / lenb;
    int p = g % lenb;
    int pos = lsb_m ? p : lenb - 1 - p;
    return txw[w][pos];
  endfunction

  function automatic logic [31:0] ctrl_word(int lc, int wc, bit lsb, bit lf, bit cf, bit go);
    return {21'b0, cf, lf, lsb, 2'(wc), 5'(lc), go};
  endfunction

  task automatic run(int lc, int wc, bit lsb, bit lf, bit cf, int div, bit inv, bit lock);
    int nw, n, hp, t;
    logic [31:0] d;
    lenb  = (lc == 0) ? 32 : lc;
    lsb_m = lsb;
    nw = wc + 1;
    n  = lenb * nw;
    hp = div + 1;
    t  = 2 * n * hp;
    for (int i = 0; i < 4; i++) begin
      txw[i] = rnd();
      wr(4'(4 + i), txw[i]);
    end
    wr(4'd1, 32'(div));
    miso_inv = inv;
    for (int i = 0; i < 4; i++) exp_rx[i] = '0;
    for (int g = 0; g < n; g++) begin
      int src = (!cf && !lf) ? ((g == 0) ? 0 : g - 1) : g;
      int w = g / lenb;
      int p = g % lenb;
      int pos = lsb ? p : lenb - 1 - p;
      exp_rx[w][pos] = txbit(src) ^ inv;
    end
    wr(4'd0, ctrl_word(lc, wc, lsb, lf, cf, 1'b1));
    for (int c = 0; c <= t + 1; c++) begin
      @(negedge clk);
      if (c < t) begin
        int h = c / hp;
        int idx = lf ? h / 2 : ((h == 0) ? 0 : (h - 1) / 2);
        chk("R2,R3,R7 select", 32'(ss_n), 32'd0);
        chk("R7 sclk", 32'(sclk), 32'(h % 2));
        chk("R4,R5 mosi", 32'(mosi), 32'(txbit(idx)));
        chk("R11 done", 32'(done), 32'd0);
        if (reg_addr == 4'd0) chk("R8 busy", 32'(rdata[0]), 32'd1);
      end else begin
        chk("R2,R7 select idle", 32'(ss_n), 32'd1);
        chk("R7 sclk idle", 32'(sclk), 32'd0);
        chk("R11 done", 32'(done), (c == t) ? 32'd1 : 32'd0);
        chk("R8 busy clear", 32'(rdata[0]), 32'd0);
      end
      if (lock) begin
        if (c == 1) begin reg_we = 1'b1; reg_addr = 4'd4; reg_wdata = ~txw[0]; end
        else if (c == 2) begin reg_addr = 4'd1; reg_wdata = 32'hbeef; end
        else if (c == 3) begin reg_addr = 4'd0; reg_wdata = ctrl_word(7, 2, !lsb, !lf, !cf, 1'b1); end
        else if (c == 4) begin reg_we = 1'b0; reg_addr = 4'd0; end
      end
    end
    for (int i = 0; i < 4; i++) begin
      rd(4'(8 + i), d);
      chk("R4,R6,R10 rx word", d, exp_rx[i]);
    end
    if (lock) begin
      rd(4'd4, d); chk("R9 tx locked", d, txw[0]);
      rd(4'd1, d); chk("R9 div locked", d, 32'(div));
      rd(4'd0, d); chk("R9 ctrl locked", d, ctrl_word(lc, wc, lsb, lf, cf, 1'b0));
    end
    reg_addr = '0;
  endtask

  initial begin
    logic [31:0] d;
    int lcs [8] = '{8, 0, 1, 5, 31, 13, 16, 3};
    repeat (3) @(negedge clk);
    // R1 during and after reset
    chk("R1 sclk", 32'(sclk), 32'd0);
    chk("R1 mosi", 32'(mosi), 32'd0);
    chk("R1 select", 32'(ss_n), 32'd1);
    chk("R1 done", 32'(done), 32'd0);
    rst_n = 1'b1;
    rd(4'd0, d); chk("R1 ctrl", d, 32'd0);
    rd(4'd1, d); chk("R1 div", d, 32'd0);
    rd(4'd4, d); chk("R1 tx0", d, 32'd0);
    rd(4'd8, d); chk("R1 rx0", d, 32'd0);

    // R8/R12: fields without go do not start
    wr(4'd0, ctrl_word(9, 3, 1'b1, 1'b0, 1'b1, 1'b0));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 no start select", 32'(ss_n), 32'd1);
      chk("R8 no start busy", 32'(rdata[0]), 32'd0);
    end
    rd(4'd0, d); chk("R12 ctrl readback", d, ctrl_word(9, 3, 1'b1, 1'b0, 1'b1, 1'b0));

    for (int i = 0; i < 8; i++) begin
      run(lcs[i], i % 4, i[2], i[0], i[1], i % 3, i[0] ^ i[1], i == 1);
    end
    run(7, 3, 1'b0, 1'b1, 1'b0, 5, 1'b1, 1'b0);
    run(32, 0, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);

    summary();
    $finish;
  end
endmodule